// File: doc/BRIEF.md
# Accumulator ALU with Flags

This block is the arithmetic and logic stage of a small 8-bit datapath. It holds an accumulator, a hidden operand register and a flag byte. The surrounding control logic loads the accumulator directly or loads the hidden operand register. It then pulses an execute strobe with an operation code. On that clock edge the block combines the accumulator with the operand register, writes the result back to the accumulator and refreshes the flag byte.

The flag byte reports the sign, zero and even-parity state of the result. It also reports the carry or borrow out of the top bit and the carry or borrow across the middle of the byte, between bit 3 and bit 4. Every register is updated on the same rising edge, so the accumulator and the flags always describe the same operation.

Top module: `acu_core`

## Requirements
- R1: An active-low asynchronous reset clears the accumulator, the operand register and the flag byte to 00h.
- R2: With `exec` low, `acc_ld` writes `acc_in` into the accumulator on the clock edge and leaves the flag byte unchanged.
- R3: `opnd_ld` writes `opnd_in` into the hidden operand register on the clock edge. The stored value is visible only through later operations.
- R4: With `exec` high, `op_sel` selects the operation: 000 add (acc+opnd), 001 subtract (acc−opnd), 010 AND, 011 OR, 100 XOR. The 8-bit result appears on `acc_out` and the new flags appear on `flags_out` on the same clock edge.
- R5: The flag byte holds: bit 7 = bit 7 of the result; bit 6 = 1 when the result is 00h; bit 4 = middle carry; bit 2 = 1 when the result has an even number of ones; bit 0 = carry. Bits 5, 3 and 1 are always 0.
- R6: For add, bit 0 is the carry out of bit 7 and bit 4 is the carry out of bit 3. Adding 88h and 99h gives 21h with flag byte 15h.
- R7: For subtract, bit 0 is 1 when the unsigned accumulator is less than the operand (a borrow). Bit 4 is 1 when the low nibble of the accumulator is less than the low nibble of the operand.
- R8: For the logical operations, bit 0 is 0. Bit 4 is 1 for AND and 0 for OR and XOR.
- R9: With `exec` high and `op_sel` set to 101, 110 or 111, the accumulator and the flag byte stay unchanged.
- R10: When `exec` and `acc_ld` are high in the same cycle, `exec` takes precedence and `acc_in` is discarded.
- R11: When `exec` and `opnd_ld` are high in the same cycle, the operation uses the operand value from before that edge. The new `opnd_in` value is kept for the next operation.
- R12: With `exec` low, the flag byte keeps its value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| op_sel | input | 3 | Operation code, sampled while `exec` is high |
| exec | input | 1 | Execute strobe |
| acc_ld | input | 1 | Accumulator load strobe |
| acc_in | input | 8 | Accumulator load value |
| opnd_ld | input | 1 | Operand register load strobe |
| opnd_in | input | 8 | Operand register load value |
| acc_out | output | 8 | Accumulator contents |
| flags_out | output | 8 | Flag byte |

## Verification
Two pairs of actions can fall in the same cycle. An execute can meet an accumulator load, and an execute can meet an operand load. The bench raises both strobes of each pair together in the same cycle, with values chosen so that every possible outcome gives a different accumulator. For the first pair, the accumulator must hold the operation result and not the load value. For the second pair, the result of that edge must use the old operand. A following execute must then show that the new operand was stored.

// File: rtl/acu_pkg.sv
package acu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'b000,
        OP_SUB = 3'b001,
        OP_AND = 3'b010,
        OP_OR  = 3'b011,
        OP_XOR = 3'b100
    } acu_op_e;

    localparam int FLAG_W   = 8;
    localparam int FB_SIGN  = 7;
    localparam int FB_ZERO  = 6;
    localparam int FB_HALF  = 4;
    localparam int FB_PAR   = 2;
    localparam int FB_CARRY = 0;

    function automatic logic op_is_valid(input logic [2:0] code);
        return code <= 3'(OP_XOR);
    endfunction

    function automatic logic op_is_arith(input logic [2:0] code);
        return (code == 3'(OP_ADD)) || (code == 3'(OP_SUB));
    endfunction

endpackage

// File: rtl/acu_arith.sv
module acu_arith #(
    parameter int W       = 8,
    parameter int HALF_AT = 4
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         do_sub,
    output logic [W-1:0] res,
    output logic         carry,
    output logic         half
);
    logic [W-1:0]       b_eff;
    logic [W:0]         full_sum;
    logic [HALF_AT:0]   low_sum;

    always_comb begin
        // subtraction reuses the adder: a + ~b + 1
        b_eff    = do_sub ? ~b : b;
        full_sum = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, do_sub};
        low_sum  = {1'b0, a[HALF_AT-1:0]} + {1'b0, b_eff[HALF_AT-1:0]}
                 + {{HALF_AT{1'b0}}, do_sub};
        res      = full_sum[W-1:0];
        // carry out of the adder is the inverted borrow on subtract
        carry    = do_sub ? ~full_sum[W] : full_sum[W];
        half     = do_sub ? ~low_sum[HALF_AT] : low_sum[HALF_AT];
    end
endmodule

// File: rtl/acu_logic.sv
module acu_logic
    import acu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [2:0]   code,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] res
);
    always_comb begin
        unique case (code)
            3'(OP_AND): res = a & b;
            3'(OP_OR):  res = a | b;
            default:    res = a ^ b;
        endcase
    end
endmodule

// File: rtl/acu_flags.sv
module acu_flags
    import acu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0]      res,
    input  logic              carry,
    input  logic              half,
    output logic [FLAG_W-1:0] flag_byte
);
    logic [W:0] par_chain;

    assign par_chain[0] = 1'b0;
    for (genvar gi = 0; gi < W; gi++) begin : g_par
        assign par_chain[gi+1] = par_chain[gi] ^ res[gi];
    end

    always_comb begin
        flag_byte           = '0;
        flag_byte[FB_SIGN]  = res[W-1];
        flag_byte[FB_ZERO]  = (res == '0);
        flag_byte[FB_HALF]  = half;
        flag_byte[FB_PAR]   = ~par_chain[W];
        flag_byte[FB_CARRY] = carry;
    end
endmodule

// File: rtl/acu_core.sv
module acu_core
    import acu_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        op_sel,
    input  logic              exec,
    input  logic              acc_ld,
    input  logic [W-1:0]      acc_in,
    input  logic              opnd_ld,
    input  logic [W-1:0]      opnd_in,
    output logic [W-1:0]      acc_out,
    output logic [FLAG_W-1:0] flags_out
);
    localparam int HALF_AT = W / 2;

    typedef struct packed {
        logic [W-1:0]      acc;
        logic [W-1:0]      opnd;
        logic [FLAG_W-1:0] flg;
    } acu_state_t;

    acu_state_t st_d, st_q;

    logic [W-1:0]      arith_res, logic_res, alu_res;
    logic              arith_cy, arith_half, cy_sel, half_sel;
    logic [FLAG_W-1:0] new_flags;

    acu_arith #(.W(W), .HALF_AT(HALF_AT)) u_arith (
        .a      (st_q.acc),
        .b      (st_q.opnd),
        .do_sub (op_sel == 3'(OP_SUB)),
        .res    (arith_res),
        .carry  (arith_cy),
        .half   (arith_half)
    );

    acu_logic #(.W(W)) u_logic (
        .code (op_sel),
        .a    (st_q.acc),
        .b    (st_q.opnd),
        .res  (logic_res)
    );

    always_comb begin
        if (op_is_arith(op_sel)) begin
            alu_res  = arith_res;
            cy_sel   = arith_cy;
            half_sel = arith_half;
        end else begin
            alu_res  = logic_res;
            cy_sel   = 1'b0;
            half_sel = (op_sel == 3'(OP_AND));
        end
    end

    acu_flags #(.W(W)) u_flags (
        .res       (alu_res),
        .carry     (cy_sel),
        .half      (half_sel),
        .flag_byte (new_flags)
    );

    always_comb begin
        st_d = st_q;
        if (opnd_ld) begin
            st_d.opnd = opnd_in;
        end
        if (exec) begin
            if (op_is_valid(op_sel)) begin
                st_d.acc = alu_res;
                st_d.flg = new_flags;
            end
        end else if (acc_ld) begin
            st_d.acc = acc_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign acc_out   = st_q.acc;
    assign flags_out = st_q.flg;

endmodule

// File: rtl/acu_core_chk.sv
module acu_core_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic [2:0]   op_sel,
    input logic         exec,
    input logic         acc_ld,
    input logic [W-1:0] acc_in,
    input logic [W-1:0] acc_out,
    input logic [7:0]   flags_out
);
    p_acc_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!exec && acc_ld) |=> (acc_out == $past(acc_in)) && $stable(flags_out));

    p_flag_fields_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_sel <= 3'd4) |=> (flags_out[7] == acc_out[W-1])
            && (flags_out[6] == (acc_out == '0))
            && (flags_out[2] == ~^acc_out));

    p_spare_bits_r5: assert property (@(posedge clk) disable iff (!rst_n)
        exec |=> (flags_out[5] == 1'b0) && (flags_out[3] == 1'b0) && (flags_out[1] == 1'b0));

    p_logic_carry_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_sel >= 3'd2 && op_sel <= 3'd4) |=>
            (flags_out[0] == 1'b0) && (flags_out[4] == ($past(op_sel) == 3'd2)));

    p_bad_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (exec && op_sel > 3'd4) |=> $stable(acc_out) && $stable(flags_out));

    p_flag_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
        !exec |=> $stable(flags_out));
endmodule

bind acu_core acu_core_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .op_sel    (op_sel),
    .exec      (exec),
    .acc_ld    (acc_ld),
    .acc_in    (acc_in),
    .acc_out   (acc_out),
    .flags_out (flags_out)
);

// File: tb/acu_core_test.sv
`timescale 1ns/1ps
module acu_core_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op_sel = 3'd0;
    logic       exec = 1'b0;
    logic       acc_ld = 1'b0;
    logic [7:0] acc_in = 8'h00;
    logic       opnd_ld = 1'b0;
    logic [7:0] opnd_in = 8'h00;
    logic [7:0] acc_out;
    logic [7:0] flags_out;

    acu_core uut (
        .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .exec(exec),
        .acc_ld(acc_ld), .acc_in(acc_in), .opnd_ld(opnd_ld),
        .opnd_in(opnd_in), .acc_out(acc_out), .flags_out(flags_out)
    );

    always #4 clk = ~clk;

    typedef struct {
        logic [7:0] acc;
        logic [7:0] flg;
        string      req;
    } exp_t;

    exp_t exp_q[$];
    int   n_checks = 0;
    int   n_fail   = 0;
    logic [7:0] m_acc = 8'h00, m_opnd = 8'h00, m_flg = 8'h00;

    // expected flag byte from the requirements
    function automatic logic [7:0] mk_flags(input logic [7:0] r, input logic cy, input logic ac);
        logic [7:0] f;
        int ones;
        ones = 0;
        for (int i = 0; i < 8; i++) ones += int'(r[i]);
        f = 8'h00;
        f[7] = r[7];
        f[6] = (r == 8'h00);
        f[4] = ac;
        f[2] = (ones % 2 == 0);
        f[0] = cy;
        return f;
    endfunction

    task automatic step(input logic [2:0] op, input logic ex,
                        input logic al, input logic [7:0] ai,
                        input logic ol, input logic [7:0] oi, input string req);
        logic [8:0] sum;
        logic [7:0] r;
        @(negedge clk);
        op_sel = op; exec = ex; acc_ld = al; acc_in = ai; opnd_ld = ol; opnd_in = oi;
        if (ex) begin
            case (op)
                3'd0: begin
                    sum = {1'b0, m_acc} + {1'b0, m_opnd};
                    r = sum[7:0];
                    m_flg = mk_flags(r, sum[8], (m_acc[3:0] + m_opnd[3:0]) > 15);
                    m_acc = r;
                end
                3'd1: begin
                    r = m_acc - m_opnd;
                    m_flg = mk_flags(r, m_acc < m_opnd, m_acc[3:0] < m_opnd[3:0]);
                    m_acc = r;
                end
                3'd2: begin r = m_acc & m_opnd; m_flg = mk_flags(r, 1'b0, 1'b1); m_acc = r; end
                3'd3: begin r = m_acc | m_opnd; m_flg = mk_flags(r, 1'b0, 1'b0); m_acc = r; end
                3'd4: begin r = m_acc ^ m_opnd; m_flg = mk_flags(r, 1'b0, 1'b0); m_acc = r; end
                default: ;
            endcase
        end else if (al) begin
            m_acc = ai;
        end
        if (ol) m_opnd = oi;
        @(posedge clk);
        #1;
        exp_q.push_back('{acc: m_acc, flg: m_flg, req: req});
        exec = 1'b0; acc_ld = 1'b0; opnd_ld = 1'b0;
    endtask

    // monitor: compare design outputs against queued expectations
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if (acc_out !== e.acc || flags_out !== e.flg) begin
                    n_fail++;
                    $display("FAIL %s: acc=%h flags=%h expected acc=%h flags=%h",
                             e.req, acc_out, flags_out, e.acc, e.flg);
                end
            end
        end
    end

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        logic [7:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        exp_q.push_back('{acc: 8'h00, flg: 8'h00, req: "R1 reset"});
        // R1: operand register cleared by reset, so acc+0 keeps the acc
        step(3'd0, 1'b0, 1'b1, 8'h05, 1'b0, 8'h00, "R2 acc load");
        step(3'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R1 operand cleared");
        // R2 flags unchanged on acc load
        step(3'd0, 1'b0, 1'b1, 8'h88, 1'b0, 8'h00, "R2 load keeps flags");
        step(3'd0, 1'b0, 1'b0, 8'h00, 1'b1, 8'h99, "R3 operand load");
        step(3'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R6 88h+99h");
        if (m_acc !== 8'h21 || m_flg !== 8'h15) $display("bench model mismatch R6");
        step(3'd0, 1'b0, 1'b1, 8'hFF, 1'b1, 8'h01, "R2 R3 setup");
        step(3'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R6 R5 wrap to zero");
        step(3'd1, 1'b0, 1'b1, 8'h10, 1'b1, 8'h01, "R2 setup sub");
        step(3'd1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R7 nibble borrow");
        step(3'd1, 1'b0, 1'b1, 8'h01, 1'b1, 8'h02, "R2 setup sub");
        step(3'd1, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R7 full borrow");
        step(3'd2, 1'b0, 1'b1, 8'hF0, 1'b1, 8'h3C, "R2 setup logic");
        step(3'd2, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R8 and");
        step(3'd3, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R8 or");
        step(3'd4, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R8 xor");
        step(3'd5, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R9 code 5");
        step(3'd7, 1'b1, 1'b1, 8'hAA, 1'b0, 8'h00, "R9 R10 code 7 with load");
        // R10: exec with acc load, result wins
        step(3'd0, 1'b0, 1'b1, 8'h40, 1'b1, 8'h02, "R2 setup");
        step(3'd0, 1'b1, 1'b1, 8'h77, 1'b0, 8'h00, "R10 exec over load");
        // R11: exec with operand load uses old operand
        step(3'd0, 1'b1, 1'b0, 8'h00, 1'b1, 8'h10, "R11 old operand");
        step(3'd0, 1'b1, 1'b0, 8'h00, 1'b0, 8'h00, "R11 new operand");
        step(3'd0, 1'b0, 1'b0, 8'h00, 1'b0, 8'h00, "R12 idle hold");
        step(3'd1, 1'b0, 1'b0, 8'h00, 1'b1, 8'h33, "R12 operand load only");
        lfsr = 8'hA5;
        for (int k = 0; k < 60; k++) begin
            logic [7:0] v;
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            v = lfsr;
            step(3'(k % 6), k[0], ~k[0] | lfsr[1], v, lfsr[2], ~v, "R4 mixed");
        end
        repeat (3) @(negedge clk);
        #2;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end
endmodule